// File: doc/BRIEF.md
# UART Multidrop Mute Controller

This block sits next to a UART receiver on a shared multidrop line, where one master talks to many slave nodes. It decides whether the local receiver is muted. While it is muted, the receive status flags and the receive interrupt stay quiet, so a node that is not addressed spends no effort on traffic meant for other nodes. Bit sampling and baud generation happen outside the block. The receiver gives the block a strobe for each completed frame with its data word and error bits, a per-bit-time tick, and a level that is high while the line rests high.

Two wake methods can be selected. In line-rest mode, mute ends once the line has stayed high for one whole frame time. That time depends on the word length and the stop-bit count. In address mode, a word whose top data bit is set is an address. If it matches the node's own address, mute ends. If it does not match, mute begins. In both modes, software can force mute with a single-cycle request.

Top module: `uart_mute_ctrl`

## Requirements
- R1: While `mute_en_i` is 0, `mute_o` is 0 and a mute request has no effect.
- R2: A frame strobed while `mute_o` is 1 leaves `rdy_o`, `ore_o`, `fe_o` and `pe_o` at 0 in the following cycle.
- R3: `irq_o` is 0 in the cycle after any cycle in which `mute_o` is 1. Outside mute it pulses with every reported frame.
- R4: A reported frame gives one-cycle pulses in the next cycle: `rdy_o` = 1, and `ore_o`, `fe_o`, `pe_o` equal the error inputs sampled with the strobe.
- R5: With `wake_sel_i` = 0 and the line not in the rested state, a request sets `mute_o` to 1 in the next cycle.
- R6: With `wake_sel_i` = 0, a request made after a full rest frame has been seen (with the line still high) is ignored.
- R7: The rest-frame length in bit ticks is 9 for `word_len_i` = 10 (7 data bits), 10 for 00 (8 bits), 11 for 01 (9 bits), and 10 for 11. Add one tick when `stop2_i` = 1. Mute ends at the edge that samples the last tick. A low on `line_idle_i` restarts the count.
- R8: With `wake_sel_i` = 1, a word is an address when bit 6, 7 or 8 is set, for codes 10, 00 and 01 respectively. A muted node that receives an address whose low `ADDR_W` bits equal `node_addr_i` leaves mute and does not report that word. A word without that bit set is data.
- R9: With `wake_sel_i` = 1, an address that does not match sets `mute_o` to 1 and is not reported.
- R10: With `wake_sel_i` = 1, a request sets `mute_o` to 1 regardless of line state.
- R11: If `mute_en_i` drops and is raised again within two cycles, `mute_o` reads 0 afterwards, and later frames are reported.
- R12: Reset clears `mute_o`, all status outputs and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mute_en_i | input | 1 | Allows muting |
| wake_sel_i | input | 1 | 0 = line-rest wake, 1 = address wake |
| mute_req_i | input | 1 | One-cycle software mute request |
| word_len_i | input | 2 | 00 = 8, 01 = 9, 10 = 7 data bits |
| stop2_i | input | 1 | Two stop bits |
| node_addr_i | input | ADDR_W | Own node address |
| bit_tick_i | input | 1 | One pulse per bit time |
| line_idle_i | input | 1 | Line is resting high |
| frame_done_i | input | 1 | Frame received strobe |
| rx_data_i | input | DATA_W | Received word |
| ore_i | input | 1 | Overrun with this frame |
| fe_i | input | 1 | Framing error with this frame |
| pe_i | input | 1 | Parity error with this frame |
| mute_o | output | 1 | Mute active |
| rdy_o | output | 1 | Gated data-ready pulse |
| ore_o | output | 1 | Gated overrun pulse |
| fe_o | output | 1 | Gated framing pulse |
| pe_o | output | 1 | Gated parity pulse |
| irq_o | output | 1 | Gated receive interrupt pulse |

## Verification
The bench builds the block with the defaults `DATA_W` = 9 and `ADDR_W` = 4. The 9-bit word width is the smallest that covers all three address-bit positions. With it, one run can show that bit 8 marks an address only in 9-bit mode, while the same word with bit 7 set passes as data. Four address bits keep the match and mismatch cases short. The counter width derived from `DATA_W` covers the longest rest frame of 12 ticks, so every word-length and stop-bit combination can be driven to its exact tick boundary.

// File: rtl/mute_pkg.sv
package mute_pkg;
  typedef enum logic [1:0] {
    WL_8   = 2'b00,
    WL_9   = 2'b01,
    WL_7   = 2'b10,
    WL_RSV = 2'b11
  } wlen_e;

  typedef struct packed {
    logic rdy;
    logic ore;
    logic fe;
    logic pe;
  } rx_flags_t;

  function automatic int unsigned data_bits(wlen_e wl);
    case (wl)
      WL_9:    return 9;
      WL_7:    return 7;
      default: return 8;
    endcase
  endfunction

  // start + data + stop(s)
  function automatic int unsigned rest_ticks(wlen_e wl, logic two_stop);
    return data_bits(wl) + 2 + (two_stop ? 1 : 0);
  endfunction
endpackage

// File: rtl/mute_idle_det.sv
module mute_idle_det #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_idle_i,
  input  logic             bit_tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             idle_hit_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             idle_q;

  assign idle_hit_o = line_idle_i & bit_tick_i & ~idle_q & (cnt_q == limit_i - 1'b1);
  assign idle_o     = idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (!line_idle_i) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (bit_tick_i && !idle_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (idle_hit_o) idle_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mute_addr_match.sv
module mute_addr_match
  import mute_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 4
) (
  input  wlen_e             wlen_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              is_addr_o,
  output logic              match_o
);
  always_comb begin
    case (wlen_i)
      WL_9:    is_addr_o = data_i[8];
      WL_7:    is_addr_o = data_i[6];
      default: is_addr_o = data_i[7];
    endcase
  end

  assign match_o = (data_i[ADDR_W-1:0] == node_addr_i);
endmodule

// File: rtl/mute_flag_gate.sv
module mute_flag_gate
  import mute_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      report_i,
  input  logic      ore_i,
  input  logic      fe_i,
  input  logic      pe_i,
  output rx_flags_t flags_o,
  output logic      irq_o
);
  rx_flags_t flags_q;
  logic      irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= report_i ? rx_flags_t'({1'b1, ore_i, fe_i, pe_i}) : rx_flags_t'('0);
      irq_q   <= report_i;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/uart_mute_ctrl.sv
module uart_mute_ctrl
  import mute_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mute_en_i,
  input  logic              wake_sel_i,
  input  logic              mute_req_i,
  input  logic [1:0]        word_len_i,
  input  logic              stop2_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              bit_tick_i,
  input  logic              line_idle_i,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              ore_i,
  input  logic              fe_i,
  input  logic              pe_i,
  output logic              mute_o,
  output logic              rdy_o,
  output logic              ore_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 4);

  wlen_e            wlen;
  logic [CNT_W-1:0] limit;
  logic             idle_hit, idle_st;
  logic             is_addr, addr_ok;
  logic             mute_q, mute_d;
  logic             addr_mode, report;
  rx_flags_t        flags;
  logic             unused_data;

  assign wlen        = wlen_e'(word_len_i);
  assign limit       = CNT_W'(rest_ticks(wlen, stop2_i));
  assign unused_data = ^rx_data_i;

  mute_idle_det #(.CNT_W(CNT_W)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_idle_i(line_idle_i),
    .bit_tick_i (bit_tick_i),
    .limit_i    (limit),
    .idle_hit_o (idle_hit),
    .idle_o     (idle_st)
  );

  mute_addr_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .wlen_i     (wlen),
    .data_i     (rx_data_i),
    .node_addr_i(node_addr_i),
    .is_addr_o  (is_addr),
    .match_o    (addr_ok)
  );

  assign addr_mode = mute_en_i & wake_sel_i;

  always_comb begin
    mute_d = mute_q;
    if (!mute_en_i) begin
      mute_d = 1'b0;
    end else if (!wake_sel_i) begin
      if (idle_hit)                     mute_d = 1'b0;
      else if (mute_req_i && !idle_st)  mute_d = 1'b1;
    end else begin
      if (frame_done_i && is_addr)      mute_d = ~addr_ok;
      else if (mute_req_i)              mute_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mute_q <= 1'b0;
    else         mute_q <= mute_d;
  end

  // flag reads 0 the moment enable drops
  assign mute_o = mute_q & mute_en_i;

  // a mismatching address mutes at once and is not reported
  assign report = frame_done_i & ~mute_o & ~(addr_mode & is_addr & ~addr_ok);

  mute_flag_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .report_i(report),
    .ore_i   (ore_i),
    .fe_i    (fe_i),
    .pe_i    (pe_i),
    .flags_o (flags),
    .irq_o   (irq_o)
  );

  assign rdy_o = flags.rdy;
  assign ore_o = flags.ore;
  assign fe_o  = flags.fe;
  assign pe_o  = flags.pe;
endmodule

// File: rtl/uart_mute_ctrl_chk.sv
module uart_mute_ctrl_chk #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mute_en_i,
  input logic              wake_sel_i,
  input logic              mute_req_i,
  input logic [1:0]        word_len_i,
  input logic [ADDR_W-1:0] node_addr_i,
  input logic              frame_done_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              mute_o,
  input logic              rdy_o,
  input logic              ore_o,
  input logic              fe_o,
  input logic              pe_o,
  input logic              irq_o
);
  assert_reenable_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!mute_en_i) && !$past(mute_req_i) && !$past(frame_done_i)) |-> !mute_o);

  assert_quiet_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |=> !(rdy_o || ore_o || fe_o || pe_o));

  assert_quiet_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |=> !irq_o);

  assert_flags_need_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> !(rdy_o || ore_o || fe_o || pe_o || irq_o));

  assert_addr_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_en_i && wake_sel_i && mute_req_i && !frame_done_i) |=> (!mute_en_i || mute_o));

  assert_addr_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_en_i && wake_sel_i && frame_done_i && word_len_i == 2'b00 && rx_data_i[7] &&
     rx_data_i[ADDR_W-1:0] != node_addr_i) |=> (!mute_en_i || mute_o));
endmodule

bind uart_mute_ctrl uart_mute_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mute_en_i   (mute_en_i),
  .wake_sel_i  (wake_sel_i),
  .mute_req_i  (mute_req_i),
  .word_len_i  (word_len_i),
  .node_addr_i (node_addr_i),
  .frame_done_i(frame_done_i),
  .rx_data_i   (rx_data_i),
  .mute_o      (mute_o),
  .rdy_o       (rdy_o),
  .ore_o       (ore_o),
  .fe_o        (fe_o),
  .pe_o        (pe_o),
  .irq_o       (irq_o)
);

// File: tb/uart_mute_ctrl_test.sv
module uart_mute_ctrl_test;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mute_en = 0, wake_sel = 0, mute_req = 0, stop2 = 0;
  logic [1:0]        word_len = 2'b00;
  logic [ADDR_W-1:0] node_addr = 4'h5;
  logic              bit_tick = 0, line_idle = 0, frame_done = 0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              ore = 0, fe = 0, pe = 0;
  logic              mute_o, rdy_o, ore_o, fe_o, pe_o, irq_o;

  always #10 clk = ~clk;

  uart_mute_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mute_en_i(mute_en), .wake_sel_i(wake_sel),
    .mute_req_i(mute_req), .word_len_i(word_len), .stop2_i(stop2),
    .node_addr_i(node_addr), .bit_tick_i(bit_tick), .line_idle_i(line_idle),
    .frame_done_i(frame_done), .rx_data_i(rx_data), .ore_i(ore), .fe_i(fe),
    .pe_i(pe), .mute_o(mute_o), .rdy_o(rdy_o), .ore_o(ore_o), .fe_o(fe_o),
    .pe_o(pe_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [4:0] val;  // {rdy, ore, fe, pe, irq}
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic fd_q = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) fd_q <= frame_done;
  always @(negedge clk) begin
    if (fd_q && rst_n) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard underflow actual=result expected=none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {3'b0, rdy_o, ore_o, fe_o, pe_o, irq_o}, {3'b0, e.val});
      end
    end
  end

  task automatic send(input logic [DATA_W-1:0] d, input logic o, input logic f,
                      input logic p, input logic rep, input string tag);
    exp_t e;
    frame_done = 1; rx_data = d; ore = o; fe = f; pe = p;
    e.val = rep ? {1'b1, o, f, p, 1'b1} : 5'b0;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    frame_done = 0; ore = 0; fe = 0; pe = 0;
  endtask

  task automatic pulse_req();
    mute_req = 1;
    @(negedge clk);
    mute_req = 0;
  endtask

  // mute by request, then hold the line high and count ticks to the wake edge
  task automatic rest_run(input logic [1:0] wl, input logic s2, input int n,
                          input bit break_once, input string tag);
    word_len = wl; stop2 = s2; line_idle = 0;
    @(negedge clk);
    pulse_req();
    chk({tag, " muted"}, {7'b0, mute_o}, 8'd1);
    line_idle = 1;
    if (break_once) begin
      bit_tick = 1;
      for (int i = 0; i < n - 1; i++) @(negedge clk);
      bit_tick = 0; line_idle = 0;
      @(negedge clk);
      line_idle = 1;
    end
    bit_tick = 1;
    for (int i = 0; i < n - 1; i++) @(negedge clk);
    chk({tag, " still muted one tick early"}, {7'b0, mute_o}, 8'd1);
    @(negedge clk);
    bit_tick = 0;
    chk({tag, " woke on last tick"}, {7'b0, mute_o}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // R12: reset holds everything clear even with a request pending
    mute_en = 1; mute_req = 1;
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {2'b0, mute_o, rdy_o, ore_o, fe_o, pe_o, irq_o}, 8'd0);
    mute_req = 0; mute_en = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: request ignored without enable
    pulse_req();
    chk("R1 request without enable", {7'b0, mute_o}, 8'd0);

    // R4: unmuted frames report their flags
    send(9'h03C, 0, 1, 0, 1, "R4 frame fe");
    send(9'h0A1, 1, 0, 1, 1, "R4 frame ore pe");
    send(9'h011, 0, 0, 0, 1, "R4 clean frame");

    // R5 and R2/R3 in line-rest mode
    mute_en = 1; wake_sel = 0; line_idle = 0;
    @(negedge clk);
    pulse_req();
    chk("R5 request while line busy", {7'b0, mute_o}, 8'd1);
    send(9'h055, 1, 1, 1, 0, "R2 R3 muted frame suppressed");
    chk("R2 still muted after frame", {7'b0, mute_o}, 8'd1);

    // R7: rest length per format
    rest_run(2'b00, 0, 10, 0, "R7 8 bits");
    // R6: request while line already rested is ignored
    pulse_req();
    chk("R6 request on rested line", {7'b0, mute_o}, 8'd0);
    rest_run(2'b01, 1, 12, 0, "R7 9 bits two stop");
    rest_run(2'b10, 0, 9, 0, "R7 7 bits");
    rest_run(2'b11, 0, 10, 0, "R7 code 11");
    rest_run(2'b00, 1, 11, 1, "R7 restart after busy");
    line_idle = 0;

    // address mode, 8-bit words
    wake_sel = 1; word_len = 2'b00; stop2 = 0;
    @(negedge clk);
    send(9'h083, 0, 0, 0, 0, "R9 mismatch not reported");
    chk("R9 mismatch mutes", {7'b0, mute_o}, 8'd1);
    send(9'h011, 0, 1, 0, 0, "R2 data suppressed in mute");
    send(9'h085, 0, 0, 0, 0, "R8 match not reported");
    chk("R8 match wakes", {7'b0, mute_o}, 8'd0);
    send(9'h022, 0, 1, 0, 1, "R4 data after wake");

    // 9-bit words: bit 8 marks address
    word_len = 2'b01;
    send(9'h085, 0, 0, 0, 1, "R8 bit7 is data in 9-bit mode");
    chk("R8 data keeps unmuted", {7'b0, mute_o}, 8'd0);
    send(9'h103, 0, 0, 0, 0, "R9 9-bit mismatch");
    chk("R9 9-bit mutes", {7'b0, mute_o}, 8'd1);
    send(9'h105, 0, 0, 0, 0, "R8 9-bit match");
    chk("R8 9-bit wakes", {7'b0, mute_o}, 8'd0);

    // 7-bit words: bit 6 marks address
    word_len = 2'b10;
    send(9'h043, 0, 0, 0, 0, "R9 7-bit mismatch");
    chk("R9 7-bit mutes", {7'b0, mute_o}, 8'd1);
    send(9'h045, 0, 0, 0, 0, "R8 7-bit match");
    chk("R8 7-bit wakes", {7'b0, mute_o}, 8'd0);

    // R10: request in address mode even with line rested
    line_idle = 1;
    pulse_req();
    chk("R10 request in address mode", {7'b0, mute_o}, 8'd1);
    line_idle = 0;
    send(9'h045, 0, 0, 0, 0, "R8 wake after request");
    chk("R8 wake after request state", {7'b0, mute_o}, 8'd0);

    // R11: quick enable toggle
    pulse_req();
    chk("R11 muted before toggle", {7'b0, mute_o}, 8'd1);
    mute_en = 0;
    @(negedge clk);
    chk("R1 flag clear while disabled", {7'b0, mute_o}, 8'd0);
    mute_en = 1;
    @(negedge clk);
    chk("R11 clear after re-enable", {7'b0, mute_o}, 8'd0);
    @(negedge clk);
    chk("R11 stays clear", {7'b0, mute_o}, 8'd0);
    send(9'h012, 0, 0, 1, 1, "R11 frame reported after toggle");

    // R11 in line-rest mode with a one-cycle drop
    wake_sel = 0;
    pulse_req();
    mute_en = 0;
    @(negedge clk);
    mute_en = 1;
    @(negedge clk);
    chk("R11 line-rest mode clear", {7'b0, mute_o}, 8'd0);
    send(9'h013, 1, 0, 0, 1, "R11 line-rest frame reported");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    finish_run();
  end
endmodule